// File: doc/BRIEF.md
# Battery-Low Check Sequencer

This block decides when a real-time clock tests its backup battery and keeps the resulting battery-low status bit. A check starts on one of two events: the device coming up out of backup mode, or the time-of-day counters rolling over at midnight while the device runs on main power. Each check optionally switches on a load across the battery, waits a fixed number of clock cycles for the battery node and the comparator to settle, then takes one sample of a digital comparator. The comparator reports whether the battery is below the internal 2.5 V reference.

A rollover check always loads the battery, so a weak or missing cell reads as low. A power-up check does not load by default, because the battery has already been under load during backup. A configuration input makes the power-up check load as well. The status bit is rewritten at every check, so it falls again after a good reading. The analog comparator, the reference and the load resistor sit outside this block.

Top module: `batt_check_seq`

## Requirements
- R1: After reset, loadEn, cmpEn and battLow are all 0.
- R2: A pwrUpEvt pulse seen while no check runs starts a check whatever the level of inBackup. cmpEn is 1 from the next cycle.
- R3: A midnightStb pulse seen while no check runs starts a check only when inBackup is 0. With inBackup at 1 it starts nothing, and cmpEn and loadEn stay 0.
- R4: A rollover check holds loadEn at 1 for every cycle of its settle interval.
- R5: A power-up check holds loadEn at 1 through the settle interval when loadOnPwrUp is 1 in the trigger cycle. It keeps loadEn at 0 when loadOnPwrUp is 0.
- R6: A check lasts exactly SETTLE_CYC settle cycles, then one sample cycle in which cmpEn is 1 and loadEn is 0. After that cmpEn returns to 0.
- R7: In the cycle after the sample cycle, battLow equals the cmpBelow value that was present in the sample cycle. A value of 1 means the battery is below the reference. A later check that samples 0 clears battLow.
- R8: cmpBelow has no effect in any cycle other than the sample cycle. battLow keeps its value through the settle cycles and while the sequencer is idle.
- R9: A pwrUpEvt or midnightStb that arrives during the settle or sample cycles is ignored. The check still ends after SETTLE_CYC+1 enabled cycles, and no second check follows it.
- R10: When pwrUpEvt and midnightStb arrive in the same idle cycle with inBackup at 0, exactly one check runs, and it loads the battery whatever the value of loadOnPwrUp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| pwrUpEvt | input | 1 | One-cycle pulse: device has left backup mode |
| midnightStb | input | 1 | One-cycle pulse: time-of-day counters rolled over at midnight |
| inBackup | input | 1 | 1 while the device runs from the backup supply |
| loadOnPwrUp | input | 1 | 1 makes power-up checks load the battery |
| cmpBelow | input | 1 | Comparator result, 1 = battery below reference |
| loadEn | output | 1 | Switches the battery load on |
| cmpEn | output | 1 | Powers the comparator during a check |
| battLow | output | 1 | Battery-low status bit |

## Verification
The two start paths can fire in the same cycle: a power-up event coinciding with a qualified midnight rollover. The bench provokes this with directed cases and with random trigger patterns. It judges the result by confirming that exactly one check of the normal length runs and that loadEn follows the rollover rule even when loadOnPwrUp is 0. A second collision, a trigger landing during a check in progress, is provoked by random pulses on both trigger inputs during settle and sample. It is judged by the check still ending after SETTLE_CYC+1 enabled cycles and by cmpEn staying low afterwards.

// File: rtl/batt_check_pkg.sv
package batt_check_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETTLE = 2'd1,
    ST_SAMPLE = 2'd2
  } seqState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic startStb;   // check accepted this cycle
    logic startLoad;  // accepted check wants the battery loaded
    logic settleOn;   // in settle interval
    logic sampleStb;  // sample cycle
  } seqStrobes_t;

endpackage

// File: rtl/batt_check_ctrl.sv
module batt_check_ctrl
  import batt_check_pkg::*;
#(
  parameter int SETTLE_CYC = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        pwrUpEvt,
  input  logic        midnightStb,
  input  logic        inBackup,
  input  logic        loadOnPwrUp,
  output seqStrobes_t strb
);

  localparam int CNT_W = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE_CYC - 1);

  seqState_t        state;
  logic [CNT_W-1:0] settleCnt;
  logic             rollQual;
  logic             anyTrig;

  assign rollQual = midnightStb & ~inBackup;
  assign anyTrig  = pwrUpEvt | rollQual;

  always_comb begin
    strb = '0;
    unique case (state)
      ST_IDLE: begin
        strb.startStb  = anyTrig;
        strb.startLoad = rollQual | (pwrUpEvt & loadOnPwrUp);
      end
      ST_SETTLE: strb.settleOn  = 1'b1;
      ST_SAMPLE: strb.sampleStb = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      settleCnt <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          settleCnt <= '0;
          if (anyTrig) state <= ST_SETTLE;
        end
        ST_SETTLE: begin
          if (settleCnt == CNT_LAST) begin
            state     <= ST_SAMPLE;
            settleCnt <= '0;
          end else begin
            settleCnt <= settleCnt + 1'b1;
          end
        end
        ST_SAMPLE: state <= ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/batt_check_dp.sv
module batt_check_dp
  import batt_check_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  seqStrobes_t strb,
  input  logic        cmpBelow,
  output logic        loadEn,
  output logic        cmpEn,
  output logic        battLow
);

  logic loadSel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loadSel <= 1'b0;
      battLow <= 1'b0;
    end else begin
      if (strb.startStb)  loadSel <= strb.startLoad;
      if (strb.sampleStb) battLow <= cmpBelow;
    end
  end

  assign loadEn = strb.settleOn & loadSel;
  assign cmpEn  = strb.settleOn | strb.sampleStb;

endmodule

// File: rtl/batt_check_seq.sv
module batt_check_seq
  import batt_check_pkg::*;
#(
  parameter int SETTLE_CYC = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic pwrUpEvt,
  input  logic midnightStb,
  input  logic inBackup,
  input  logic loadOnPwrUp,
  input  logic cmpBelow,
  output logic loadEn,
  output logic cmpEn,
  output logic battLow
);

  seqStrobes_t strb;

  batt_check_ctrl #(.SETTLE_CYC(SETTLE_CYC)) u_ctrl (
    .clk(clk), .rstN(rstN), .pwrUpEvt(pwrUpEvt), .midnightStb(midnightStb),
    .inBackup(inBackup), .loadOnPwrUp(loadOnPwrUp), .strb(strb)
  );

  batt_check_dp u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .cmpBelow(cmpBelow),
    .loadEn(loadEn), .cmpEn(cmpEn), .battLow(battLow)
  );

endmodule

// File: rtl/batt_check_seq_chk.sv
module batt_check_seq_chk #(
  parameter int SETTLE_CYC = 8
) (
  input logic clk,
  input logic rstN,
  input logic pwrUpEvt,
  input logic midnightStb,
  input logic inBackup,
  input logic cmpBelow,
  input logic loadEn,
  input logic cmpEn,
  input logic battLow
);

  localparam int RUN_W = $clog2(SETTLE_CYC + 2) + 1;
  localparam logic [RUN_W-1:0] RUN_EXP = RUN_W'(SETTLE_CYC + 1);

  logic [RUN_W-1:0] runLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      runLen <= '0;
    else if (cmpEn) runLen <= runLen + 1'b1;
    else            runLen <= '0;
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rstN |-> (!loadEn && !cmpEn && !battLow));

  // R2
  pwrup_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!cmpEn && pwrUpEvt) |=> cmpEn);

  // R3
  backup_roll_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!cmpEn && midnightStb && inBackup && !pwrUpEvt) |=> (!cmpEn && !loadEn));

  // R6
  load_inside_check_chk: assert property (@(posedge clk) disable iff (!rstN)
    loadEn |-> cmpEn);

  // R6
  load_off_in_sample_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(cmpEn) |-> !$past(loadEn));

  // R9
  run_length_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(cmpEn) |-> runLen == RUN_EXP);

  // R7
  status_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(cmpEn) |-> battLow == $past(cmpBelow));

  // R8
  status_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(battLow) |-> $fell(cmpEn));

endmodule

bind batt_check_seq batt_check_seq_chk #(.SETTLE_CYC(SETTLE_CYC)) u_chk (
  .clk(clk), .rstN(rstN), .pwrUpEvt(pwrUpEvt), .midnightStb(midnightStb),
  .inBackup(inBackup), .cmpBelow(cmpBelow), .loadEn(loadEn), .cmpEn(cmpEn),
  .battLow(battLow)
);

// File: tb/batt_check_seq_bench.sv
module batt_check_seq_bench;

  localparam int SETTLE = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pwrUpEvt = 1'b0, midnightStb = 1'b0, inBackup = 1'b0;
  logic loadOnPwrUp = 1'b0, cmpBelow = 1'b0;
  logic loadEn, cmpEn, battLow;

  int checks = 0;
  int failures = 0;
  logic expBl = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  batt_check_seq #(.SETTLE_CYC(SETTLE)) u_batt_check_seq (
    .clk(clk), .rstN(rstN), .pwrUpEvt(pwrUpEvt), .midnightStb(midnightStb),
    .inBackup(inBackup), .loadOnPwrUp(loadOnPwrUp), .cmpBelow(cmpBelow),
    .loadEn(loadEn), .cmpEn(cmpEn), .battLow(battLow)
  );

  function automatic logic expStart(logic pu, logic mid, logic bk);
    return pu | (mid & ~bk);
  endfunction

  function automatic logic expLoad(logic pu, logic mid, logic bk, logic cfg);
    return (mid & ~bk) | (pu & cfg);
  endfunction

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b t=%0t", req, act, exp, $time);
    end
  endtask

  // Drive one trigger pattern and follow it to its end.
  task automatic runCheck(logic pu, logic mid, logic bk, logic cfg,
                          logic cmpv, bit noise, string tag);
    logic st, ld;
    st = expStart(pu, mid, bk);
    ld = expLoad(pu, mid, bk, cfg);
    @(negedge clk);
    pwrUpEvt = pu; midnightStb = mid; inBackup = bk; loadOnPwrUp = cfg;
    @(negedge clk);
    pwrUpEvt = 1'b0; midnightStb = 1'b0;
    if (!st) begin
      chk({tag, " R3 no start cmpEn"}, cmpEn, 1'b0);
      chk({tag, " R3 no start loadEn"}, loadEn, 1'b0);
      chk({tag, " R8 idle hold"}, battLow, expBl);
      return;
    end
    chk({tag, " R2 cmpEn on"}, cmpEn, 1'b1);
    chk({tag, " R4 R5 R10 loadEn"}, loadEn, ld);
    for (int i = 1; i < SETTLE; i++) begin
      if (noise) begin
        cmpBelow = 1'($urandom);
        pwrUpEvt = 1'($urandom);
        midnightStb = 1'($urandom);
      end
      @(negedge clk);
      chk({tag, " R6 settle cmpEn"}, cmpEn, 1'b1);
      chk({tag, " R4 R5 settle loadEn"}, loadEn, ld);
      chk({tag, " R8 hold in settle"}, battLow, expBl);
    end
    if (noise) begin
      pwrUpEvt = 1'($urandom);
      midnightStb = 1'($urandom);
    end
    cmpBelow = ~cmpv;
    @(negedge clk);
    chk({tag, " R6 sample cmpEn"}, cmpEn, 1'b1);
    chk({tag, " R6 sample loadEn"}, loadEn, 1'b0);
    chk({tag, " R8 hold before sample"}, battLow, expBl);
    cmpBelow = cmpv;
    if (noise) begin
      pwrUpEvt = 1'($urandom);
      midnightStb = 1'($urandom);
    end
    @(negedge clk);
    expBl = cmpv;
    pwrUpEvt = 1'b0; midnightStb = 1'b0;
    cmpBelow = 1'($urandom);
    chk({tag, " R7 captured"}, battLow, expBl);
    chk({tag, " R9 ended"}, cmpEn, 1'b0);
    @(negedge clk);
    chk({tag, " R9 no restart"}, cmpEn, 1'b0);
    chk({tag, " R8 idle hold"}, battLow, expBl);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired t=%0t", $time);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7321));
    repeat (3) @(negedge clk);
    chk("R1 reset loadEn", loadEn, 1'b0);
    chk("R1 reset cmpEn", cmpEn, 1'b0);
    chk("R1 reset battLow", battLow, 1'b0);
    rstN = 1'b1;
    cmpBelow = 1'b1;
    @(negedge clk);
    chk("R8 cmp ignored idle", battLow, 1'b0);

    runCheck(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, "roll");
    runCheck(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "pu_noload");
    runCheck(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, "pu_load");
    runCheck(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "roll_backup");
    runCheck(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, "coincide");
    runCheck(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, "coincide_bk");

    for (int n = 0; n < 300; n++) begin
      runCheck(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
               1'($urandom), 1'b1, "rand");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule